// File: doc/BRIEF.md
# Fused Read-Modify-Write Instruction Sequencer

This block carries out the multi-cycle part of the combined memory-update instructions of an 8-bit accumulator processor. Each instruction reads one memory byte, changes it (decrement, increment, shift or rotate), writes it back, and then merges the changed byte into the accumulator or the flags. The changes are a compare after a decrement, a subtract with borrow after an increment, an AND after a left rotate, an add with carry after a right rotate, an OR after a left shift and an XOR after a right shift.

The surrounding core has already fetched the opcode and its operand bytes. It raises `start` for one cycle with the opcode, the operand bytes and the current A, X, Y, carry and overflow values. The sequencer latches them, drives the memory bus through pointer fetches, index arithmetic and dummy reads, and raises `done` in the last cycle of the instruction with the new accumulator and flags. The bus uses registered address, write data and write enable. Read data must be valid before the clock edge that closes the cycle in which the address is shown. A write takes effect at that same edge.

Top module: `rmw_fused_seq`

## Requirements
- R1: Opcode bits [1:0] must be 11. Bits [7:5] select the operation: 000 shift-left/OR, 001 rotate-left/AND, 010 shift-right/XOR, 011 rotate-right/add, 110 decrement/compare, 111 increment/subtract. Any other opcode on `start` is ignored: `busy` stays low and no write occurs.
- R2: Opcode bits {[4],[3:2]} select the addressing mode. 001 is zero-page and takes 5 cycles. 011 is absolute and takes 6. 101 is zero-page,X and takes 6. 111 is absolute,X and takes 7. 110 is absolute,Y and takes 7. 000 is (zero-page,X) indirect and takes 8. 100 is (zero-page),Y indirect and takes 8. The count includes the `start` cycle as cycle 1, and `done` is high in the last cycle. A page crossing adds no cycle. Pattern 010 is rejected as in R1.
- R3: Each instruction makes exactly two writes, in consecutive cycles, to the effective address. The first write carries the unmodified byte and the second carries the modified byte. `done` is high in the cycle of the second write and only then.
- R4: Zero-page,X addresses and both indirect pointer byte addresses wrap within page zero. Absolute indexed addresses and the indirect,Y final address use a full 16-bit add.
- R5: Decrement/compare stores value-1. A is unchanged. C = (A >= new value), Z = (A == new value), N = bit 7 of A minus new value.
- R6: Increment/subtract stores value+1. A becomes A - new - (1 - C). C is set when no borrow occurs, and V is signed overflow of the subtraction.
- R7: Rotate-left/AND stores {value[6:0], C} and A becomes A AND that byte. Shift-left/OR stores {value[6:0], 0} and A becomes A OR that byte. In both cases C = value bit 7.
- R8: Rotate-right/add stores {C, value[7:1]} and A becomes A + that byte + value bit 0, with C and V taken from the addition. Shift-right/XOR stores {0, value[7:1]}, A becomes A XOR that byte, and C = value bit 0.
- R9: Only increment/subtract and rotate-right/add change V. Every other operation returns the V given at `start`. N and Z follow the new A for every operation except decrement/compare.
- R10: A `start` that arrives while `busy` is high is ignored. Operand and register inputs are sampled only in the accepted `start` cycle.
- R11: After reset, `busy`, `done` and `mem_we` are low, and the accumulator and flag outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an instruction (accepted only when idle) |
| opcode | input | 8 | Instruction opcode |
| oper_lo | input | 8 | First operand byte |
| oper_hi | input | 8 | Second operand byte (absolute modes) |
| a_in | input | 8 | Accumulator value |
| x_in | input | 8 | X index value |
| y_in | input | 8 | Y index value |
| c_in | input | 1 | Carry flag value |
| v_in | input | 1 | Overflow flag value |
| mem_rdata | input | 8 | Read data for the current address |
| mem_addr | output | 16 | Bus address |
| mem_wdata | output | 8 | Bus write data |
| mem_we | output | 1 | Bus write enable |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Last cycle of the instruction; results valid |
| a_out | output | 8 | New accumulator |
| n_out | output | 1 | New negative flag |
| v_out | output | 1 | New overflow flag |
| z_out | output | 1 | New zero flag |
| c_out | output | 1 | New carry flag |

## Verification
The properties assume a memory that answers within the cycle and never stalls. They also assume that `start` with a new opcode comes only while `busy` is low, or is meant to be dropped. The bench memory is a plain array with a same-cycle read. Random opcodes are drawn only from the legal family and mode encodings, and the rejected encodings and mid-instruction `start` pulses are applied as separate directed cases. The directed cases also place pointers and indexed bases at $FF so that the page-zero wrap and the page crossing of absolute indexing are exercised.

// File: rtl/rmw_seq_pkg.sv
package rmw_seq_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 16;
  localparam int PAGE_W = ADDR_W - DATA_W;

  typedef enum logic [2:0] {
    F_SLO, F_RLA, F_SRE, F_RRA, F_DCP, F_ISC
  } fam_e;

  typedef enum logic [2:0] {
    M_IZX, M_ZP, M_ABS, M_IZY, M_ZPX, M_ABSY, M_ABSX
  } mode_e;

  typedef enum logic [3:0] {
    S_IDLE, S_OPR1, S_OPR2, S_DUMMY, S_PLO, S_PHI, S_READ, S_WOLD, S_WNEW
  } state_e;

  typedef struct packed {
    logic n;
    logic v;
    logic z;
    logic c;
  } flags_t;
endpackage

// File: rtl/rmw_decode.sv
module rmw_decode
  import rmw_seq_pkg::*;
(
  input  logic [DATA_W-1:0] op,
  output logic              valid,
  output fam_e              fam,
  output mode_e             mode
);
  logic fam_ok, mode_ok;

  always_comb begin
    fam_ok = 1'b1;
    fam    = F_SLO;
    case (op[7:5])
      3'b000: fam = F_SLO;
      3'b001: fam = F_RLA;
      3'b010: fam = F_SRE;
      3'b011: fam = F_RRA;
      3'b110: fam = F_DCP;
      3'b111: fam = F_ISC;
      default: fam_ok = 1'b0;
    endcase
  end

  always_comb begin
    mode_ok = 1'b1;
    mode    = M_ZP;
    case ({op[4], op[3:2]})
      3'b000: mode = M_IZX;
      3'b001: mode = M_ZP;
      3'b011: mode = M_ABS;
      3'b100: mode = M_IZY;
      3'b101: mode = M_ZPX;
      3'b110: mode = M_ABSY;
      3'b111: mode = M_ABSX;
      default: mode_ok = 1'b0;
    endcase
  end

  assign valid = fam_ok && mode_ok && (op[1:0] == 2'b11);
endmodule

// File: rtl/rmw_alu.sv
module rmw_alu
  import rmw_seq_pkg::*;
(
  input  fam_e              fam,
  input  logic [DATA_W-1:0] val,
  input  logic [DATA_W-1:0] acc,
  input  logic              c_in,
  input  logic              v_in,
  output logic [DATA_W-1:0] mod_val,
  output logic [DATA_W-1:0] acc_new,
  output flags_t            fl
);
  localparam int MSB = DATA_W - 1;
  logic [DATA_W:0] sum;

  always_comb begin
    mod_val = val;
    acc_new = acc;
    sum     = '0;
    fl.n    = 1'b0;
    fl.z    = 1'b0;
    fl.c    = c_in;
    fl.v    = v_in;
    case (fam)
      F_DCP: begin
        mod_val = val - DATA_W'(1);
        sum     = {1'b0, acc} + {1'b0, ~mod_val} + (DATA_W+1)'(1);
        fl.c    = sum[DATA_W];
      end
      F_ISC: begin
        mod_val = val + DATA_W'(1);
        sum     = {1'b0, acc} + {1'b0, ~mod_val} + {{DATA_W{1'b0}}, c_in};
        acc_new = sum[MSB:0];
        fl.c    = sum[DATA_W];
        fl.v    = (acc[MSB] ^ mod_val[MSB]) & (acc[MSB] ^ acc_new[MSB]);
      end
      F_RLA: begin
        mod_val = {val[MSB-1:0], c_in};
        acc_new = acc & mod_val;
        fl.c    = val[MSB];
      end
      F_RRA: begin
        mod_val = {c_in, val[MSB:1]};
        sum     = {1'b0, acc} + {1'b0, mod_val} + {{DATA_W{1'b0}}, val[0]};
        acc_new = sum[MSB:0];
        fl.c    = sum[DATA_W];
        fl.v    = ~(acc[MSB] ^ mod_val[MSB]) & (acc[MSB] ^ acc_new[MSB]);
      end
      F_SLO: begin
        mod_val = {val[MSB-1:0], 1'b0};
        acc_new = acc | mod_val;
        fl.c    = val[MSB];
      end
      F_SRE: begin
        mod_val = {1'b0, val[MSB:1]};
        acc_new = acc ^ mod_val;
        fl.c    = val[0];
      end
      default: ;
    endcase
    if (fam == F_DCP) begin
      fl.n = sum[MSB];
      fl.z = (sum[MSB:0] == '0);
    end else begin
      fl.n = acc_new[MSB];
      fl.z = (acc_new == '0);
    end
  end
endmodule

// File: rtl/rmw_agen.sv
module rmw_agen
  import rmw_seq_pkg::*;
(
  input  state_e            nxt,
  input  mode_e             mode,
  input  logic [DATA_W-1:0] lo,
  input  logic [DATA_W-1:0] hi,
  input  logic [DATA_W-1:0] xr,
  input  logic [DATA_W-1:0] yr,
  input  logic [DATA_W-1:0] ptr_lo,
  input  logic [DATA_W-1:0] ptr_hi,
  output logic [ADDR_W-1:0] addr,
  output logic              hold
);
  localparam logic [PAGE_W-1:0] ZPAGE = '0;

  logic [DATA_W-1:0] lo_x, lo_y, lo_x1, lo_1, plo_y;
  logic [ADDR_W-1:0] abs_a, ptr_a;

  assign lo_x  = lo + xr;
  assign lo_y  = lo + yr;
  assign lo_x1 = lo + xr + DATA_W'(1);
  assign lo_1  = lo + DATA_W'(1);
  assign plo_y = ptr_lo + yr;
  assign abs_a = {hi, lo};
  assign ptr_a = {ptr_hi, ptr_lo};

  always_comb begin
    hold = 1'b0;
    addr = '0;
    case (nxt)
      S_DUMMY: begin
        case (mode)
          M_ZPX, M_IZX: addr = {ZPAGE, lo};
          M_ABSX:       addr = {hi, lo_x};
          M_ABSY:       addr = {hi, lo_y};
          M_IZY:        addr = {ptr_hi, plo_y};
          default:      hold = 1'b1;
        endcase
      end
      S_PLO: addr = (mode == M_IZX) ? {ZPAGE, lo_x}  : {ZPAGE, lo};
      S_PHI: addr = (mode == M_IZX) ? {ZPAGE, lo_x1} : {ZPAGE, lo_1};
      S_READ: begin
        case (mode)
          M_ZP:   addr = {ZPAGE, lo};
          M_ABS:  addr = abs_a;
          M_ZPX:  addr = {ZPAGE, lo_x};
          M_ABSX: addr = abs_a + {ZPAGE, xr};
          M_ABSY: addr = abs_a + {ZPAGE, yr};
          M_IZX:  addr = ptr_a;
          M_IZY:  addr = ptr_a + {ZPAGE, yr};
          default: hold = 1'b1;
        endcase
      end
      default: hold = 1'b1;
    endcase
  end
endmodule

// File: rtl/rmw_fused_seq.sv
module rmw_fused_seq
  import rmw_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] opcode,
  input  logic [DATA_W-1:0] oper_lo,
  input  logic [DATA_W-1:0] oper_hi,
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] x_in,
  input  logic [DATA_W-1:0] y_in,
  input  logic              c_in,
  input  logic              v_in,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] a_out,
  output logic              n_out,
  output logic              v_out,
  output logic              z_out,
  output logic              c_out
);
  state_e state, nxt;
  fam_e   dec_fam, fam_q;
  mode_e  dec_mode, mode_q;
  logic   dec_valid, accept;

  logic [DATA_W-1:0] lo_q, hi_q, a_q, x_q, y_q;
  logic              c_q, v_q;
  logic [DATA_W-1:0] ptr_lo_q, ptr_hi_q, ptr_hi_eff, val_q;
  logic [DATA_W-1:0] alu_mod, alu_acc;
  flags_t            alu_fl;
  logic [ADDR_W-1:0] nxt_addr;
  logic              addr_hold;

  rmw_decode u_dec (
    .op    (opcode),
    .valid (dec_valid),
    .fam   (dec_fam),
    .mode  (dec_mode)
  );

  assign accept     = start && (state == S_IDLE) && dec_valid;
  assign ptr_hi_eff = (state == S_PHI) ? mem_rdata : ptr_hi_q;

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE:  if (accept) nxt = S_OPR1;
      S_OPR1: begin
        case (mode_q)
          M_ZP:                 nxt = S_READ;
          M_ABS, M_ABSX, M_ABSY: nxt = S_OPR2;
          M_ZPX, M_IZX:         nxt = S_DUMMY;
          default:              nxt = S_PLO;
        endcase
      end
      S_OPR2:  nxt = (mode_q == M_ABS) ? S_READ : S_DUMMY;
      S_DUMMY: nxt = (mode_q == M_IZX) ? S_PLO : S_READ;
      S_PLO:   nxt = S_PHI;
      S_PHI:   nxt = (mode_q == M_IZX) ? S_READ : S_DUMMY;
      S_READ:  nxt = S_WOLD;
      S_WOLD:  nxt = S_WNEW;
      S_WNEW:  nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  rmw_agen u_agen (
    .nxt    (nxt),
    .mode   (mode_q),
    .lo     (lo_q),
    .hi     (hi_q),
    .xr     (x_q),
    .yr     (y_q),
    .ptr_lo (ptr_lo_q),
    .ptr_hi (ptr_hi_eff),
    .addr   (nxt_addr),
    .hold   (addr_hold)
  );

  rmw_alu u_alu (
    .fam     (fam_q),
    .val     (val_q),
    .acc     (a_q),
    .c_in    (c_q),
    .v_in    (v_q),
    .mod_val (alu_mod),
    .acc_new (alu_acc),
    .fl      (alu_fl)
  );

  // operand and register capture
  always_ff @(posedge clk) begin
    if (rst) begin
      fam_q  <= F_SLO;
      mode_q <= M_ZP;
      lo_q   <= '0;
      hi_q   <= '0;
      a_q    <= '0;
      x_q    <= '0;
      y_q    <= '0;
      c_q    <= 1'b0;
      v_q    <= 1'b0;
    end else if (accept) begin
      fam_q  <= dec_fam;
      mode_q <= dec_mode;
      lo_q   <= oper_lo;
      hi_q   <= oper_hi;
      a_q    <= a_in;
      x_q    <= x_in;
      y_q    <= y_in;
      c_q    <= c_in;
      v_q    <= v_in;
    end
  end

  // sequencing, data capture and bus drive
  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      ptr_lo_q  <= '0;
      ptr_hi_q  <= '0;
      val_q     <= '0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_we    <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
    end else begin
      state <= nxt;
      if (state == S_PLO)  ptr_lo_q <= mem_rdata;
      if (state == S_PHI)  ptr_hi_q <= mem_rdata;
      if (state == S_READ) val_q    <= mem_rdata;
      if (!addr_hold)      mem_addr <= nxt_addr;
      mem_we <= (nxt == S_WOLD) || (nxt == S_WNEW);
      if (nxt == S_WOLD)      mem_wdata <= mem_rdata;
      else if (nxt == S_WNEW) mem_wdata <= alu_mod;
      busy <= (nxt != S_IDLE);
      done <= (nxt == S_WNEW);
    end
  end

  // architectural results, valid from the final write cycle on
  always_ff @(posedge clk) begin
    if (rst) begin
      a_out <= '0;
      n_out <= 1'b0;
      v_out <= 1'b0;
      z_out <= 1'b0;
      c_out <= 1'b0;
    end else if (state == S_WOLD) begin
      a_out <= alu_acc;
      n_out <= alu_fl.n;
      v_out <= alu_fl.v;
      z_out <= alu_fl.z;
      c_out <= alu_fl.c;
    end
  end
endmodule

// File: rtl/rmw_fused_seq_chk.sv
module rmw_fused_seq_chk
  import rmw_seq_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] opcode,
  input logic [DATA_W-1:0] a_in,
  input logic              v_in,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] a_out,
  input logic              v_out
);
  logic [2:0]        fam_bits_q;
  logic [DATA_W-1:0] a_seen_q;
  logic              v_seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fam_bits_q <= '0;
      a_seen_q   <= '0;
      v_seen_q   <= 1'b0;
    end else if (start && !busy) begin
      fam_bits_q <= opcode[7:5];
      a_seen_q   <= a_in;
      v_seen_q   <= v_in;
    end
  end

  p_write_pair_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we) |=> mem_we);
  p_write_limit_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |=> !mem_we);
  p_same_target_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr)));
  p_done_on_second_write_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> (mem_we && $past(mem_we)));
  p_done_single_r3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_write_needs_busy_r3: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);
  p_compare_keeps_a_r5: assert property (@(posedge clk) disable iff (rst)
    (done && fam_bits_q == 3'b110) |-> (a_out == a_seen_q));
  p_v_untouched_r9: assert property (@(posedge clk) disable iff (rst)
    (done && fam_bits_q[1:0] != 2'b11) |-> (v_out == v_seen_q));
endmodule

bind rmw_fused_seq rmw_fused_seq_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .opcode   (opcode),
  .a_in     (a_in),
  .v_in     (v_in),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .a_out    (a_out),
  .v_out    (v_out)
);

// File: tb/rmw_fused_seq_tb_top.sv
`timescale 1ns/1ps
module rmw_fused_seq_tb_top;
  localparam int MEM_AW = 12;
  localparam int MEM_N  = 1 << MEM_AW;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  opcode = '0, oper_lo = '0, oper_hi = '0;
  logic [7:0]  a_in = '0, x_in = '0, y_in = '0;
  logic        c_in = 1'b0, v_in = 1'b0;
  logic [7:0]  mem_rdata;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_we, busy, done;
  logic [7:0]  a_out;
  logic        n_out, v_out, z_out, c_out;

  logic [7:0]  mem [0:MEM_N-1];
  int          wr_cnt;
  logic [15:0] wr_addr [0:3];
  logic [7:0]  wr_data [0:3];
  int          n_tests = 0;
  int          n_fail  = 0;

  always #10 clk = ~clk;

  rmw_fused_seq dut_i (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode),
    .oper_lo(oper_lo), .oper_hi(oper_hi), .a_in(a_in), .x_in(x_in),
    .y_in(y_in), .c_in(c_in), .v_in(v_in), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .busy(busy), .done(done), .a_out(a_out), .n_out(n_out),
    .v_out(v_out), .z_out(z_out), .c_out(c_out)
  );

  assign mem_rdata = mem[mem_addr[MEM_AW-1:0]];

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr[MEM_AW-1:0]] <= mem_wdata;
      if (wr_cnt < 4) begin
        wr_addr[wr_cnt] <= mem_addr;
        wr_data[wr_cnt] <= mem_wdata;
      end
      wr_cnt <= wr_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_cycles(input logic [7:0] op);
    case (op[4:0])
      5'h07:        return 5;
      5'h0F, 5'h17: return 6;
      5'h1B, 5'h1F: return 7;
      default:      return 8;
    endcase
  endfunction

  function automatic logic [15:0] exp_ea(input logic [7:0] op, lo, hi, x, y);
    logic [7:0] p;
    case (op[4:0])
      5'h03: begin p = lo + x; return {mem[8'(p + 8'd1)], mem[p]}; end
      5'h07: return {8'h00, lo};
      5'h0F: return {hi, lo};
      5'h13: return {mem[8'(lo + 8'd1)], mem[lo]} + {8'h00, y};
      5'h17: return {8'h00, 8'(lo + x)};
      5'h1B: return {hi, lo} + {8'h00, y};
      default: return {hi, lo} + {8'h00, x};
    endcase
  endfunction

  task automatic ref_op(input logic [7:0] op, val, a, input logic c, v,
                        output logic [7:0] m, ra, output logic rn, rv, rz, rc);
    logic [8:0] s;
    rv = v; rc = c; ra = a; m = val; s = '0;
    case (op[7:5])
      3'b110: begin m = val - 8'd1; s = {1'b0, a} - {1'b0, m}; rc = (a >= m); end
      3'b111: begin
        m = val + 8'd1; s = {1'b0, a} - {1'b0, m} - {8'd0, ~c};
        ra = s[7:0]; rc = !s[8];
        rv = (a[7] != m[7]) && (ra[7] != a[7]);
      end
      3'b001: begin m = {val[6:0], c}; ra = a & m; rc = val[7]; end
      3'b011: begin
        m = {c, val[7:1]}; s = {1'b0, a} + {1'b0, m} + {8'd0, val[0]};
        ra = s[7:0]; rc = s[8];
        rv = (a[7] == m[7]) && (ra[7] != a[7]);
      end
      3'b000: begin m = {val[6:0], 1'b0}; ra = a | m; rc = val[7]; end
      default: begin m = {1'b0, val[7:1]}; ra = a ^ m; rc = val[0]; end
    endcase
    if (op[7:5] == 3'b110) begin rn = s[7]; rz = (s[7:0] == 0); end
    else begin rn = ra[7]; rz = (ra == 0); end
  endtask

  function automatic string fam_req(input logic [7:0] op);
    case (op[7:5])
      3'b110: return "R5";
      3'b111: return "R6";
      3'b001, 3'b000: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic run_op(input logic [7:0] op, lo, hi, a, x, y,
                        input logic c, v, input bit poke);
    logic [15:0] ea;
    logic [7:0]  old, em, ea_acc;
    logic        en, ev, ez, ec;
    int          cyc, ecyc;
    bit          got;
    string       rq;
    ea = exp_ea(op, lo, hi, x, y);
    old = mem[ea[MEM_AW-1:0]];
    ref_op(op, old, a, c, v, em, ea_acc, en, ev, ez, ec);
    ecyc = exp_cycles(op);
    rq = fam_req(op);
    @(negedge clk);
    wr_cnt = 0;
    opcode = op; oper_lo = lo; oper_hi = hi; a_in = a; x_in = x; y_in = y;
    c_in = c; v_in = v; start = 1'b1;
    cyc = 1; got = 0;
    while (!got && cyc < 20) begin
      @(negedge clk);
      cyc++;
      start = 1'b0;
      if (poke) begin
        // R10: disturb every input while the instruction runs
        opcode = 8'hE7; oper_lo = ~lo; oper_hi = ~hi; a_in = ~a;
        x_in = ~x; y_in = ~y; c_in = ~c; v_in = ~v;
        start = (cyc == 3);
      end
      if (done) got = 1;
    end
    chk(got && cyc == ecyc, "R2 cycle count", cyc, ecyc);
    chk(a_out == ea_acc, {rq, " accumulator"}, a_out, ea_acc);
    chk({n_out, z_out, c_out} == {en, ez, ec}, {rq, " NZC"}, {n_out, z_out, c_out}, {en, ez, ec});
    chk(v_out == ev, "R9 overflow flag", v_out, ev);
    @(negedge clk);
    start = 1'b0;
    chk(wr_cnt == 2, "R3 write count", wr_cnt, 2);
    chk(wr_addr[0] == ea && wr_addr[1] == ea, "R4 effective address", wr_addr[1], ea);
    chk(wr_data[0] == old, "R3 first write holds old byte", wr_data[0], old);
    chk(wr_data[1] == em, {rq, " stored byte"}, wr_data[1], em);
    if (poke) chk(!busy && !done, "R10 ignored start left no work", busy, 0);
  endtask

  task automatic run_bad(input logic [7:0] op);
    bit seen;
    @(negedge clk);
    wr_cnt = 0;
    opcode = op; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    seen = 0;
    for (int i = 0; i < 6; i++) begin
      if (busy || done) seen = 1;
      @(negedge clk);
    end
    chk(!seen && wr_cnt == 0, "R1 rejected opcode", wr_cnt, 0);
  endtask

  initial begin
    #(20 * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] fams [6];
    logic [7:0] modes [7];
    fams  = '{8'h00, 8'h20, 8'h40, 8'h60, 8'hC0, 8'hE0};
    modes = '{8'h03, 8'h07, 8'h0F, 8'h13, 8'h17, 8'h1B, 8'h1F};
    void'($urandom(32'd20240611));
    wr_cnt = 0;
    for (int i = 0; i < MEM_N; i++) mem[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(!busy && !done && !mem_we, "R11 control outputs in reset", {busy, done, mem_we}, 0);
    chk(a_out == 0 && {n_out, v_out, z_out, c_out} == 0, "R11 result outputs in reset", a_out, 0);
    rst = 1'b0;
    @(negedge clk);

    // directed corner cases
    mem[8'h01] = 8'h40;
    run_op(8'hD7, 8'hFF, 8'h00, 8'h3F, 8'h02, 8'h00, 1'b0, 1'b1, 0); // R4 zp,X wrap; R5 equal compare
    mem[8'hFF] = 8'h34; mem[8'h00] = 8'h02;
    run_op(8'h03, 8'hFE, 8'h00, 8'h01, 8'h01, 8'h00, 1'b0, 1'b0, 0); // R4 pointer wrap, indirect X
    run_op(8'h53, 8'hFF, 8'h00, 8'h55, 8'h00, 8'hF0, 1'b1, 1'b0, 0); // R4 pointer wrap, indirect Y
    run_op(8'h7F, 8'hF0, 8'h12, 8'h10, 8'h20, 8'h00, 1'b0, 1'b0, 0); // R4 page cross, no extra cycle
    mem[16'h0040] = 8'h01;
    run_op(8'h67, 8'h40, 8'h00, 8'h10, 8'h00, 8'h00, 1'b0, 1'b0, 0); // R8 shifted-out bit feeds add
    mem[16'h0041] = 8'h01;
    run_op(8'hE7, 8'h41, 8'h00, 8'h05, 8'h00, 8'h00, 1'b0, 1'b0, 0); // R6 borrow in
    mem[16'h0042] = 8'h7F;
    run_op(8'hE7, 8'h42, 8'h00, 8'h7F, 8'h00, 8'h00, 1'b1, 1'b0, 0); // R6 signed overflow
    mem[16'h0043] = 8'h00;
    run_op(8'hC7, 8'h43, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 0); // R5 wrap to FF
    run_op(8'h2F, 8'h34, 8'h05, 8'h0F, 8'h00, 8'h00, 1'b1, 1'b1, 1); // R10 start while busy
    run_op(8'h1B, 8'hFF, 8'h01, 8'hA5, 8'h00, 8'h01, 1'b0, 1'b1, 1); // R10 and R7 with poke
    run_bad(8'h0B);
    run_bad(8'h87);
    run_bad(8'hA7);
    run_bad(8'h02);
    run_bad(8'h4C);

    // constrained random
    for (int k = 0; k < 400; k++) begin
      run_op(fams[$urandom % 6] | modes[$urandom % 7], 8'($urandom), 8'($urandom),
             8'($urandom), 8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom),
             ($urandom % 8) == 0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule